// File: doc/BRIEF.md
# Superframe DS1 Frame-Bit Inserter

This block builds DS1 frames from an unbroken serial payload stream. Each frame is 193 bit periods long: one framing bit followed by 192 payload bits (24 channels of 8 bits). The framing bits of twelve consecutive frames form a fixed superframe word, and that word repeats for as long as framing runs. A small counter selects each framing bit through a case decode. Payload bits are never robbed, replaced or reordered.

The line and the payload run at the same bit rate, and every bit period is marked by a one-cycle strobe. Each inserted framing bit therefore pushes the payload one bit period further behind. A bit buffer absorbs this growing lag. When framing is switched off, the block becomes a plain two-register pass-through and the buffered payload is discarded. A marker output flags the bit period that carries each framing bit, so a downstream stage can align to the frame without decoding the stream.

Top module: `sf_framer`

## Requirements
- R1: While `clr_n` is low, `line_out` and `fbit_mark` are 0, the bit position returns to the framing slot, the superframe position returns to its first entry, and the buffer empties. The first strobe after clear with `frame_on` high emits framing bit 1 and raises `fbit_mark`.
- R2: With framing on, one framing slot occurs on every 193rd strobe, and 192 payload slots come between two framing slots.
- R3: The framing bits of successive frames are 1,0,0,0,1,1,0,1,1,1,0,0 (first entry first), and the sequence then starts again at the first entry.
- R4: Every payload bit sampled while framing is on appears exactly once on `line_out`, in its original order and with its value unchanged, in the payload slots.
- R5: Latency. In pass-through, the bit sampled at strobe k is on `line_out` after strobe k+1. In framing mode, each framing slot after the first adds one more strobe of delay to the payload.
- R6: `fbit_mark` is 1 after a strobe that emitted a framing bit and 0 after a strobe that emitted a payload bit.
- R7: With `frame_on` low, the payload passes through with the R5 latency, no bits are inserted, and `fbit_mark` stays 0. The next strobe with `frame_on` high is a framing slot carrying the first pattern entry, followed by the last bit sampled during pass-through.
- R8: An all-zeros or all-ones payload appears on `line_out` unchanged, except in the framing slots.
- R9: Outputs and internal state change only on strobes. Without `bit_stb`, `line_out` and `fbit_mark` hold.
- R10: The buffer holds the delay built up over `BUF_DEPTH` framing slots without losing payload.
- R11: A clear in the middle of a stream restarts framing from the first pattern entry, with the R1 alignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| bit_stb | input | 1 | One-cycle strobe per line bit period |
| frame_on | input | 1 | 1 inserts framing bits, 0 passes the payload through |
| pay_in | input | 1 | Serial payload bit, sampled on strobes |
| line_out | output | 1 | Framed serial bit |
| fbit_mark | output | 1 | High while `line_out` carries a framing bit |

## Verification
Two things can fall on the same strobe: inserting a framing bit, and taking in the payload bit that was held during pass-through. On the strobe where `frame_on` rises, that held bit has to go into the buffer rather than the bypass path. The bench provokes this by running pass-through and then raising `frame_on` mid-stream. It judges the result by requiring the first payload bit after that framing bit to equal the last bit sampled before the switch, and every later payload bit to follow in order.

// File: rtl/sf_framer_pkg.sv
`timescale 1ns/1ps
package sf_framer_pkg;

   // Number of frames in one superframe; the decode in sf_pattern holds this many entries.
   localparam int unsigned SF_PATTERN_LEN = 12;

   // Where the output register takes its next bit from.
   typedef enum logic [2:0] {
      SRC_NONE   = 3'd0,
      SRC_PASS   = 3'd1,
      SRC_FBIT   = 3'd2,
      SRC_FIFO   = 3'd3,
      SRC_BYPASS = 3'd4
   } dsrc_e;

endpackage

// File: rtl/sf_bit_pos.sv
`timescale 1ns/1ps
module sf_bit_pos #(
   parameter int unsigned FRAME_BITS = 193
) (
   input  logic clk,
   input  logic clr_n,
   input  logic adv,
   input  logic restart,
   output logic at_slot
);
   localparam int unsigned PW = $clog2(FRAME_BITS);
   localparam logic [PW-1:0] LAST = PW'(FRAME_BITS - 1);

   generate
      if (FRAME_BITS < 2) begin : g_bad_len
         $error("sf_bit_pos: FRAME_BITS must be at least 2");
      end
   endgenerate

   logic [PW-1:0] pos;

   always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n) begin
         pos <= '0;
      end else if (restart) begin
         pos <= '0;
      end else if (adv) begin
         pos <= (pos == LAST) ? '0 : pos + 1'b1;
      end
   end

   assign at_slot = (pos == '0);

   AST_POS_RANGE: assert property (@(posedge clk) disable iff (!clr_n)
      pos <= LAST);  // R2
   AST_POS_WRAP: assert property (@(posedge clk) disable iff (!clr_n)
      (adv && !restart && pos == LAST) |=> at_slot);  // R2
   AST_POS_RESTART: assert property (@(posedge clk) disable iff (!clr_n)
      restart |=> at_slot);  // R7

endmodule

// File: rtl/sf_pattern.sv
`timescale 1ns/1ps
module sf_pattern
   import sf_framer_pkg::*;
#(
   parameter int unsigned SF_FRAMES = SF_PATTERN_LEN
) (
   input  logic clk,
   input  logic clr_n,
   input  logic step,
   input  logic restart,
   output logic fbit
);
   localparam int unsigned IW = $clog2(SF_FRAMES);
   localparam logic [IW-1:0] LAST = IW'(SF_FRAMES - 1);

   generate
      if (SF_FRAMES != SF_PATTERN_LEN) begin : g_bad_len
         $error("sf_pattern: the decode covers exactly 12 superframe entries");
      end
   endgenerate

   logic [IW-1:0] idx;

   always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n) begin
         idx <= '0;
      end else if (restart) begin
         idx <= '0;
      end else if (step) begin
         idx <= (idx == LAST) ? '0 : idx + 1'b1;
      end
   end

   // The framing word is picked entry by entry from the counter.
   always_comb begin
      case (idx)
         IW'(0):  fbit = 1'b1;
         IW'(1):  fbit = 1'b0;
         IW'(2):  fbit = 1'b0;
         IW'(3):  fbit = 1'b0;
         IW'(4):  fbit = 1'b1;
         IW'(5):  fbit = 1'b1;
         IW'(6):  fbit = 1'b0;
         IW'(7):  fbit = 1'b1;
         IW'(8):  fbit = 1'b1;
         IW'(9):  fbit = 1'b1;
         IW'(10): fbit = 1'b0;
         IW'(11): fbit = 1'b0;
         default: fbit = 1'b0;
      endcase
   end

   AST_SF_RANGE: assert property (@(posedge clk) disable iff (!clr_n)
      idx <= LAST);  // R3
   AST_SF_WRAP: assert property (@(posedge clk) disable iff (!clr_n)
      (step && !restart && idx == LAST) |=> idx == '0);  // R3
   AST_SF_RESTART: assert property (@(posedge clk) disable iff (!clr_n)
      restart |=> idx == '0);  // R7

endmodule

// File: rtl/sf_bit_fifo.sv
`timescale 1ns/1ps
module sf_bit_fifo #(
   parameter int unsigned DEPTH = 64
) (
   input  logic clk,
   input  logic clr_n,
   input  logic flush,
   input  logic push,
   input  logic wdata,
   input  logic pop,
   output logic rdata,
   output logic empty,
   output logic full
);
   localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CW = $clog2(DEPTH + 1);
   localparam bit POW2 = ((1 << AW) == DEPTH);
   localparam logic [AW-1:0] ALAST = AW'(DEPTH - 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("sf_bit_fifo: DEPTH must be at least 2");
      end
   endgenerate

   logic [DEPTH-1:0] mem;
   logic [AW-1:0] wp, rp, wp_nx, rp_nx;
   logic [CW-1:0] cnt;

   // Power-of-two depths wrap on their own; other depths compare against the last address.
   generate
      if (POW2) begin : g_pow2
         assign wp_nx = wp + 1'b1;
         assign rp_nx = rp + 1'b1;
      end else begin : g_wrap
         assign wp_nx = (wp == ALAST) ? '0 : wp + 1'b1;
         assign rp_nx = (rp == ALAST) ? '0 : rp + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push) begin
         mem[wp] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else if (flush) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push) wp <= wp_nx;
         if (pop)  rp <= rp_nx;
         cnt <= cnt + CW'(push) - CW'(pop);
      end
   end

   assign rdata = mem[rp];
   assign empty = (cnt == '0);
   assign full  = (cnt == CW'(DEPTH));

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!clr_n)
      (push && !pop && !flush) |-> !full);  // R10
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!clr_n)
      pop |-> !empty);  // R4
   AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!clr_n)
      flush |=> empty);  // R7

endmodule

// File: rtl/sf_framer.sv
`timescale 1ns/1ps
module sf_framer
   import sf_framer_pkg::*;
#(
   parameter int unsigned CHANNELS  = 24,
   parameter int unsigned CH_BITS   = 8,
   parameter int unsigned SF_FRAMES = SF_PATTERN_LEN,
   parameter int unsigned BUF_DEPTH = 64
) (
   input  logic clk,
   input  logic clr_n,
   input  logic bit_stb,
   input  logic frame_on,
   input  logic pay_in,
   output logic line_out,
   output logic fbit_mark
);
   localparam int unsigned PAY_BITS   = CHANNELS * CH_BITS;
   localparam int unsigned FRAME_BITS = PAY_BITS + 1;

   generate
      if (CHANNELS == 0 || CH_BITS == 0) begin : g_bad_geom
         $error("sf_framer: CHANNELS and CH_BITS must be non-zero");
      end
      if (BUF_DEPTH < 2) begin : g_bad_buf
         $error("sf_framer: BUF_DEPTH must be at least 2");
      end
   endgenerate

   // Input stage: first of the two pass-through registers.
   logic in_q, in_v;

   always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n) begin
         in_q <= 1'b0;
         in_v <= 1'b0;
      end else if (bit_stb) begin
         in_q <= pay_in;
         in_v <= 1'b1;
      end
   end

   logic at_slot, fbit;
   logic f_rdata, f_empty, f_full;
   logic f_push, f_pop, f_flush;
   logic pos_adv, sf_step, hold_reset;
   dsrc_e src;

   assign pos_adv    = bit_stb && frame_on;
   assign hold_reset = bit_stb && !frame_on;
   assign sf_step    = bit_stb && frame_on && at_slot;

   sf_bit_pos #(.FRAME_BITS(FRAME_BITS)) u_pos (
      .clk     (clk),
      .clr_n   (clr_n),
      .adv     (pos_adv),
      .restart (hold_reset),
      .at_slot (at_slot)
   );

   sf_pattern #(.SF_FRAMES(SF_FRAMES)) u_pat (
      .clk     (clk),
      .clr_n   (clr_n),
      .step    (sf_step),
      .restart (hold_reset),
      .fbit    (fbit)
   );

   // Source select: framing slot, then buffered payload, then the input register directly.
   always_comb begin
      if (!frame_on)     src = SRC_PASS;
      else if (at_slot)  src = SRC_FBIT;
      else if (!f_empty) src = SRC_FIFO;
      else if (in_v)     src = SRC_BYPASS;
      else               src = SRC_NONE;
   end

   assign f_push  = bit_stb && in_v && ((src == SRC_FBIT) || (src == SRC_FIFO));
   assign f_pop   = bit_stb && (src == SRC_FIFO);
   assign f_flush = hold_reset;

   sf_bit_fifo #(.DEPTH(BUF_DEPTH)) u_buf (
      .clk   (clk),
      .clr_n (clr_n),
      .flush (f_flush),
      .push  (f_push),
      .wdata (in_q),
      .pop   (f_pop),
      .rdata (f_rdata),
      .empty (f_empty),
      .full  (f_full)
   );

   // Output stage: second register; the marker travels with the bit.
   always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n) begin
         line_out  <= 1'b0;
         fbit_mark <= 1'b0;
      end else if (bit_stb) begin
         unique case (src)
            SRC_PASS:   line_out <= in_q;
            SRC_FBIT:   line_out <= fbit;
            SRC_FIFO:   line_out <= f_rdata;
            SRC_BYPASS: line_out <= in_q;
            default:    line_out <= 1'b0;
         endcase
         fbit_mark <= (src == SRC_FBIT);
      end
   end

   AST_SLOT_MARK: assert property (@(posedge clk) disable iff (!clr_n)
      (bit_stb && frame_on && at_slot) |=> fbit_mark);  // R6
   AST_SLOT_VALUE: assert property (@(posedge clk) disable iff (!clr_n)
      (bit_stb && frame_on && at_slot) |=> line_out == $past(fbit));  // R3
   AST_PAYLOAD_NO_MARK: assert property (@(posedge clk) disable iff (!clr_n)
      (bit_stb && frame_on && !at_slot) |=> !fbit_mark);  // R6
   AST_PASS_NO_MARK: assert property (@(posedge clk) disable iff (!clr_n)
      (bit_stb && !frame_on) |=> !fbit_mark);  // R7
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!clr_n)
      !bit_stb |=> ($stable(line_out) && $stable(fbit_mark)));  // R9
   AST_BUF_ROOM: assert property (@(posedge clk) disable iff (!clr_n)
      (bit_stb && frame_on && at_slot && in_v) |-> !f_full);  // R10

endmodule

// File: tb/test_sf_framer.sv
`timescale 1ns/1ps
module test_sf_framer;
   localparam int FB = 193;
   localparam int SFL = 12;
   localparam logic [11:0] PAT = 12'b100011011100;

   logic clk = 1'b0;
   logic clr_n = 1'b0;
   logic bit_stb = 1'b0;
   logic frame_on = 1'b0;
   logic pay_in = 1'b0;
   logic line_out, fbit_mark;

   always #10 clk = ~clk;

   sf_framer i_sf_framer (
      .clk       (clk),
      .clr_n     (clr_n),
      .bit_stb   (bit_stb),
      .frame_on  (frame_on),
      .pay_in    (pay_in),
      .line_out  (line_out),
      .fbit_mark (fbit_mark)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;
   logic xs [0:8191];
   int sidx = 0;
   int n0 = -1;
   logic prev_fe = 1'b0;
   logic [15:0] lfsr = 16'hACE1;

   task automatic chk(input logic act, input logic exp, input string req);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s at strobe %0d: got %b expected %b", req, sidx, act, exp);
      end
   endtask

   function automatic logic nextbit();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      return lfsr[0];
   endfunction

   task automatic do_clear(input logic fe, input string req);
      @(negedge clk);
      clr_n = 1'b0; bit_stb = 1'b0; frame_on = fe; pay_in = 1'b0;
      repeat (3) @(negedge clk);
      chk(line_out, 1'b0, req);
      chk(fbit_mark, 1'b0, req);
      clr_n = 1'b1;
      sidx = 0; n0 = -1; prev_fe = 1'b0;
   endtask

   // One strobe, then compare the outputs with the model built from the requirements.
   task automatic strobe(input logic d, input logic fe, input string rq_slot, input string rq_pay);
      logic e_d, e_p;
      int m, base;
      @(negedge clk);
      pay_in = d; frame_on = fe; bit_stb = 1'b1;
      xs[sidx] = d;
      if (fe && !prev_fe) n0 = sidx;
      prev_fe = fe;
      if (fe) begin
         m = sidx - n0;
         if (m % FB == 0) begin
            e_d = PAT[11 - ((m / FB) % SFL)];
            e_p = 1'b1;
         end else begin
            base = (n0 == 0) ? 0 : n0 - 1;
            e_d = xs[base + m - 1 - m / FB];
            e_p = 1'b0;
         end
      end else begin
         e_d = (sidx == 0) ? 1'b0 : xs[sidx - 1];
         e_p = 1'b0;
      end
      @(negedge clk);
      bit_stb = 1'b0;
      chk(line_out, e_d, e_p ? rq_slot : rq_pay);
      chk(fbit_mark, e_p, e_p ? rq_slot : rq_pay);
      sidx++;
   endtask

   task automatic idle(input int n);
      logic pd, pp;
      pd = line_out; pp = fbit_mark;
      repeat (n) @(negedge clk);
      chk(line_out, pd, "R9");
      chk(fbit_mark, pp, "R9");
   endtask

   task automatic t_reset();
      do_clear(1'b1, "R1");
      idle(4);
      strobe(1'b0, 1'b1, "R1", "R1");
   endtask

   task automatic t_const(input logic val, input int frames, input string slot_tag);
      do_clear(1'b1, "R1");
      for (int i = 0; i < frames * FB; i++) strobe(val, 1'b1, slot_tag, "R8");
   endtask

   task automatic t_random();
      do_clear(1'b1, "R1");
      for (int i = 0; i < 30 * FB; i++) begin
         if (i >= 29 * FB)               strobe(nextbit(), 1'b1, "R6", "R10");
         else if (i % FB == 1 && i > FB) strobe(nextbit(), 1'b1, "R6", "R5");
         else                            strobe(nextbit(), 1'b1, "R6", "R4");
         if (i % 97 == 50) idle(3);
      end
   endtask

   task automatic t_pass_switch();
      do_clear(1'b0, "R1");
      for (int i = 0; i < 300; i++) strobe(nextbit(), 1'b0, "R7", "R5");
      for (int i = 0; i < 3 * FB + 5; i++) begin
         if (i == 1) strobe(nextbit(), 1'b1, "R7", "R7");
         else        strobe(nextbit(), 1'b1, "R7", "R4");
      end
      for (int i = 0; i < 60; i++) strobe(nextbit(), 1'b0, "R7", "R7");
      for (int i = 0; i < FB + 3; i++) strobe(nextbit(), 1'b1, "R7", "R4");
   endtask

   task automatic t_clear_mid();
      do_clear(1'b1, "R1");
      for (int i = 0; i < 400; i++) strobe(nextbit(), 1'b1, "R11", "R11");
      do_clear(1'b1, "R11");
      for (int i = 0; i < 250; i++) strobe(nextbit(), 1'b1, "R11", "R11");
   endtask

   initial begin
      t_reset();
      t_const(1'b0, 13, "R2");
      t_const(1'b1, 14, "R3");
      t_random();
      t_pass_switch();
      t_clear_mid();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      #(20 * 190000);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run did not complete, got hang expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule